// File: doc/BRIEF.md
# Paired Link Register Read Merger

This unit lets a requester treat two devices that share one port as if they were a single link. Each request names one of three link registers (status, control or error). The unit reaches the devices through an index/data register window on a simple memory-mapped master. For each device it first writes the index register, which selects the device and the register, and then makes one access to the data register.

A read in dual-device mode fetches the register from device 0 and then from device 1. It returns one 32-bit value. The error register is the bitwise OR of the two values. Status and control are merged one 4-bit field at a time by fixed precedence lists. A write in dual-device mode sends the same value to device 0 and then to device 1. When the single-device input is high, only device 0 is accessed and its value is returned unmerged.

One request is in flight at a time. A busy flag covers the whole sequence, and a register code outside the three known codes is answered at once with an error response.

Top module: `pair_reg_merger`

## Requirements
- R1: The register code is 0 for status, 1 for error and 2 for control. A request with code 3 gets a response with `rsp_err` high in the cycle after acceptance and causes no window traffic.
- R2: A device access is a write of the index word to window offset 0, then a data access at offset 4. The index word holds the device number in bit 8 and a selector in bits 7:0 (status 0, control 1, error 2). In dual-device mode device 0 is accessed before device 1.
- R3: For a dual-device status read, each of nibbles 0 to 2 takes the common value when the two nibbles are equal. Otherwise it takes the first list entry that equals either nibble, using these lists: nibble 0 {1,3,0,4,3}, nibble 1 {2,1,0}, nibble 2 {6,2,1,0}.
- R4: When neither differing nibble appears in its list, the merged nibble is the last entry of that list.
- R5: For a dual-device control read the lists are: nibble 0 {1,0,4,0}, nibble 1 {0,2,1,0}, nibble 2 {0,1,2,3,0}. The equality and first-match rules are the same as for status.
- R6: For status and control, nibbles 3 to 7 of the result are device 0's nibbles.
- R7: A dual-device error read returns the bitwise OR of the two devices' values.
- R8: With `single_dev` high, a read returns device 0's value unchanged, a write changes only device 0, and the index word never names device 1.
- R9: A dual-device write stores the same value in both devices, device 0 first, and its response has `rsp_err` low.
- R10: `busy` is high from acceptance until the response. Requests presented while busy are ignored. Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and there is no window traffic while idle.
- R11: While `mm_valid` is high and `mm_ready` is low, `mm_valid`, `mm_write`, `mm_addr` and `mm_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_dev | input | 1 | Only device 0 present; sampled at acceptance |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 2 | Register code (0 status, 1 error, 2 control) |
| req_wdata | input | 32 | Write value |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected (bad register code) |
| rsp_rdata | output | 32 | Merged read value (zero for writes and errors) |
| mm_valid | output | 1 | Window access request |
| mm_write | output | 1 | Window access is a write |
| mm_addr | output | 4 | Window byte offset (0 index, 4 data) |
| mm_wdata | output | 32 | Window write data |
| mm_ready | input | 1 | Window completes the access this cycle |
| mm_rdata | input | 32 | Window read data, valid with mm_ready |

## Verification
On every cycle, the assertions check that the window handshake holds steady while it is stalled, that there is no traffic while idle, that the index word never names device 1 in single-device mode, that each response is a single pulse, and that a bad code is rejected one cycle after acceptance. They also check that error reads cover both devices' bits and that equal low nibbles pass through. Only the bench scenarios show the actual precedence choices (first match and last-entry fallback) for each list and that the upper nibbles come from device 0. They also show the device order of the mirrored writes and that a request made while busy changes no device register.

// File: rtl/pair_merge_pkg.sv
package pair_merge_pkg;

    localparam int DW       = 32;
    localparam int NIB      = 4;
    localparam int NNIB     = DW / NIB;
    localparam int LIST_MAX = 6;
    localparam int DEV_BIT  = 8;

    typedef enum logic [1:0] {
        REG_STATUS  = 2'd0,
        REG_ERROR   = 2'd1,
        REG_CONTROL = 2'd2,
        REG_BAD     = 2'd3
    } reg_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INDEX,
        ST_DATA,
        ST_RESP
    } seq_state_e;

    // Entry i sits at ent[i*NIB +: NIB]; len == 0 means no list.
    typedef struct packed {
        logic [3:0]              len;
        logic [LIST_MAX*NIB-1:0] ent;
    } prec_list_t;

    function automatic prec_list_t list_for(reg_code_e kind, int nib);
        prec_list_t l;
        l = '0;
        if (kind == REG_STATUS) begin
            case (nib)
                0: begin l.len = 4'd5; l.ent = 24'h034031; end
                1: begin l.len = 4'd3; l.ent = 24'h000012; end
                2: begin l.len = 4'd4; l.ent = 24'h000126; end
                default: l = '0;
            endcase
        end else if (kind == REG_CONTROL) begin
            case (nib)
                0: begin l.len = 4'd4; l.ent = 24'h000401; end
                1: begin l.len = 4'd4; l.ent = 24'h000120; end
                2: begin l.len = 4'd5; l.ent = 24'h003210; end
                default: l = '0;
            endcase
        end
        return l;
    endfunction

    function automatic logic [7:0] sel_code(reg_code_e kind);
        case (kind)
            REG_STATUS:  return 8'd0;
            REG_CONTROL: return 8'd1;
            REG_ERROR:   return 8'd2;
            default:     return 8'd0;
        endcase
    endfunction

    function automatic logic [NIB-1:0] pick_nibble(prec_list_t l,
                                                   logic [NIB-1:0] c0,
                                                   logic [NIB-1:0] c1);
        logic [NIB-1:0] res;
        logic           found;
        int             last;
        last  = (l.len == 4'd0) ? 0 : int'(l.len) - 1;
        res   = l.ent[last*NIB +: NIB];
        found = 1'b0;
        for (int i = 0; i < LIST_MAX; i++) begin
            if (!found && (i < int'(l.len)) &&
                ((l.ent[i*NIB +: NIB] == c0) || (l.ent[i*NIB +: NIB] == c1))) begin
                res   = l.ent[i*NIB +: NIB];
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/pair_merge_unit.sv
module pair_merge_unit
    import pair_merge_pkg::*;
(
    input  reg_code_e       kind,
    input  logic            single,
    input  logic [DW-1:0]   v0,
    input  logic [DW-1:0]   v1,
    output logic [DW-1:0]   merged
);

    for (genvar g = 0; g < NNIB; g++) begin : g_nib
        prec_list_t     lst;
        logic [NIB-1:0] a;
        logic [NIB-1:0] b;
        logic [NIB-1:0] m;

        always_comb begin
            lst = list_for(kind, g);
            a   = v0[g*NIB +: NIB];
            b   = v1[g*NIB +: NIB];
            if (single)
                m = a;
            else if (kind == REG_ERROR)
                m = a | b;
            else if ((lst.len == 4'd0) || (a == b))
                m = a;
            else
                m = pick_nibble(lst, a, b);
        end

        assign merged[g*NIB +: NIB] = m;
    end

endmodule

// File: rtl/pair_window_seq.sv
module pair_window_seq
    import pair_merge_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int IDX_OFF  = 0,
    parameter int DATA_OFF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    input  reg_code_e         start_kind,
    input  logic [DW-1:0]     start_data,
    input  logic              start_single,
    output logic              busy,
    output logic              done,
    output logic              err_o,
    output logic              write_o,
    output logic              single_o,
    output reg_code_e         kind_o,
    output logic [DW-1:0]     v0_o,
    output logic [DW-1:0]     v1_o,
    output logic              mm_valid,
    output logic              mm_write,
    output logic [ADDR_W-1:0] mm_addr,
    output logic [DW-1:0]     mm_wdata,
    input  logic              mm_ready,
    input  logic [DW-1:0]     mm_rdata
);

    localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(IDX_OFF);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFF);

    seq_state_e    state_q;
    reg_code_e     kind_q;
    logic          write_q, single_q, dev_q, err_q;
    logic [DW-1:0] data_q, v0_q, v1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= REG_STATUS;
            write_q  <= 1'b0;
            single_q <= 1'b0;
            dev_q    <= 1'b0;
            err_q    <= 1'b0;
            data_q   <= '0;
            v0_q     <= '0;
            v1_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    kind_q   <= start_kind;
                    write_q  <= start_write;
                    single_q <= start_single;
                    data_q   <= start_data;
                    dev_q    <= 1'b0;
                    v0_q     <= '0;
                    v1_q     <= '0;
                    err_q    <= (start_kind == REG_BAD);
                    state_q  <= (start_kind == REG_BAD) ? ST_RESP : ST_INDEX;
                end
                ST_INDEX: if (mm_ready) state_q <= ST_DATA;
                ST_DATA: if (mm_ready) begin
                    if (!write_q) begin
                        if (dev_q) v1_q <= mm_rdata;
                        else       v0_q <= mm_rdata;
                    end
                    if (!dev_q && !single_q) begin
                        dev_q   <= 1'b1;
                        state_q <= ST_INDEX;
                    end else begin
                        state_q <= ST_RESP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mm_valid = (state_q == ST_INDEX) || (state_q == ST_DATA);
        mm_write = (state_q == ST_INDEX) || write_q;
        mm_addr  = (state_q == ST_DATA) ? A_DATA : A_IDX;
        if (state_q == ST_DATA)
            mm_wdata = write_q ? data_q : '0;
        else if (state_q == ST_INDEX)
            mm_wdata = {{(DW-DEV_BIT-1){1'b0}}, dev_q, sel_code(kind_q)};
        else
            mm_wdata = '0;
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_RESP);
    assign err_o    = err_q;
    assign write_o  = write_q;
    assign single_o = single_q;
    assign kind_o   = kind_q;
    assign v0_o     = v0_q;
    assign v1_o     = v1_q;

    // R11: a stalled window access holds its request
    assert_mm_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mm_valid && !mm_ready) |=> (mm_valid && $stable(mm_addr) &&
                                     $stable(mm_wdata) && $stable(mm_write)));

    // R10: no window traffic while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mm_valid);

    // R10: one response strobe per request
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: single-device mode never selects device 1
    assert_single_dev0_R8: assert property (@(posedge clk) disable iff (rst)
        (mm_valid && mm_addr == A_IDX && single_q) |-> !mm_wdata[DEV_BIT]);

endmodule

// File: rtl/pair_reg_merger.sv
module pair_reg_merger
    import pair_merge_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              single_dev,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_reg,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              mm_valid,
    output logic              mm_write,
    output logic [ADDR_W-1:0] mm_addr,
    output logic [31:0]       mm_wdata,
    input  logic              mm_ready,
    input  logic [31:0]       mm_rdata
);

    logic          start, err_w, write_w, single_w;
    reg_code_e     kind_w;
    logic [DW-1:0] v0_w, v1_w, merged_w;

    assign start = req_valid && !busy;

    pair_window_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_write  (req_write),
        .start_kind   (reg_code_e'(req_reg)),
        .start_data   (req_wdata),
        .start_single (single_dev),
        .busy         (busy),
        .done         (rsp_valid),
        .err_o        (err_w),
        .write_o      (write_w),
        .single_o     (single_w),
        .kind_o       (kind_w),
        .v0_o         (v0_w),
        .v1_o         (v1_w),
        .mm_valid     (mm_valid),
        .mm_write     (mm_write),
        .mm_addr      (mm_addr),
        .mm_wdata     (mm_wdata),
        .mm_ready     (mm_ready),
        .mm_rdata     (mm_rdata)
    );

    pair_merge_unit u_merge (
        .kind   (kind_w),
        .single (single_w),
        .v0     (v0_w),
        .v1     (v1_w),
        .merged (merged_w)
    );

    assign rsp_err   = rsp_valid && err_w;
    assign rsp_rdata = (rsp_valid && !err_w && !write_w) ? merged_w : '0;

    // R1: a bad register code is refused on the next cycle
    assert_bad_code_R1: assert property (@(posedge clk) disable iff (rst)
        (start && req_reg == 2'd3) |=> (rsp_valid && rsp_err));

    // R7: merged error covers both devices' bits
    assert_err_cover_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && !write_w && !single_w && kind_w == REG_ERROR)
        |-> (((rsp_rdata & v0_w) == v0_w) && ((rsp_rdata & v1_w) == v1_w)));

    // R3: equal low nibbles pass through unchanged
    assert_equal_nib_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && !write_w && kind_w != REG_ERROR &&
         v0_w[3:0] == v1_w[3:0]) |-> (rsp_rdata[3:0] == v0_w[3:0]));

endmodule

// File: tb/pair_reg_merger_bench.sv
module pair_reg_merger_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        single_dev = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_reg = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mm_valid, mm_write, mm_ready;
    logic [3:0]  mm_addr;
    logic [31:0] mm_wdata, mm_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pair_reg_merger u_pair_reg_merger (
        .clk(clk), .rst(rst), .single_dev(single_dev),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
        .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mm_valid(mm_valid),
        .mm_write(mm_write), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_ready(mm_ready), .mm_rdata(mm_rdata)
    );

    // Window model: selector 0 status, 1 control, 2 error; device in bit 8
    logic [31:0] regs [0:1][0:2];
    logic [31:0] idx_reg = '0;
    logic        ready_t = 1'b0;
    int          n_idx = 0;
    int          n_data = 0;
    logic        log_dev [0:15];
    int          hold_viol = 0;
    logic        pv_valid = 1'b0;
    logic        pv_ready = 1'b0;
    logic [3:0]  pv_addr = '0;
    logic [31:0] pv_wdata = '0;

    assign mm_ready = ready_t;
    assign mm_rdata = (idx_reg[1:0] == 2'd3) ? 32'h0 : regs[idx_reg[8]][idx_reg[1:0]];

    always @(posedge clk) begin
        ready_t <= rst ? 1'b0 : ~ready_t;
        if (!rst && mm_valid && mm_ready) begin
            if (mm_addr == 4'd0) begin
                idx_reg <= mm_wdata;
                n_idx   <= n_idx + 1;
            end else begin
                if (mm_write && idx_reg[1:0] != 2'd3)
                    regs[idx_reg[8]][idx_reg[1:0]] <= mm_wdata;
                log_dev[n_data[3:0]] <= idx_reg[8];
                n_data <= n_data + 1;
            end
        end
    end

    // R11 monitor sampled away from the edge
    always @(negedge clk) begin
        if (!rst && pv_valid && !pv_ready &&
            (!mm_valid || mm_addr != pv_addr || mm_wdata != pv_wdata))
            hold_viol <= hold_viol + 1;
        pv_valid <= mm_valid; pv_ready <= mm_ready;
        pv_addr  <= mm_addr;  pv_wdata <= mm_wdata;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] got_data;
    logic        got_err;
    logic        got_busy;

    task automatic do_req(input bit wr, input logic [1:0] code, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_reg = code; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got_busy = busy;
        for (int i = 0; i < 200; i++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        got_data = rsp_rdata;
        got_err  = rsp_err;
    endtask

    task automatic load(input int sel, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        regs[0][sel] = a;
        regs[1][sel] = b;
    endtask

    task automatic t_reset;
        check(!busy && !rsp_valid && !mm_valid, "R10 reset idle",
              {29'b0, busy, rsp_valid, mm_valid}, 32'h0);
    endtask

    task automatic t_status_merge;
        int d0, i0;
        load(0, 32'h12345103, 32'h98765213);
        d0 = n_data; i0 = n_idx;
        do_req(1'b0, 2'd0, '0);
        check(got_data == 32'h12345213, "R3 R6 status merge", got_data, 32'h12345213);
        check(!got_err, "R3 no error", {31'b0, got_err}, 32'h0);
        check((n_data - d0) == 2 && (n_idx - i0) == 2, "R2 two accesses",
              32'(n_data - d0), 32'd2);
        check(log_dev[d0[3:0]] == 1'b0 && log_dev[4'(d0 + 1)] == 1'b1, "R2 device order",
              {30'b0, log_dev[d0[3:0]], log_dev[4'(d0 + 1)]}, 32'h1);
    endtask

    task automatic t_status_fallback;
        load(0, 32'h00000735, 32'hFFFFF846);
        do_req(1'b0, 2'd0, '0);
        check(got_data == 32'h00000003, "R4 last-entry fallback", got_data, 32'h00000003);
    endtask

    task automatic t_control_merge;
        load(1, 32'hAAAAA314, 32'h55555222);
        do_req(1'b0, 2'd2, '0);
        check(got_data == 32'hAAAAA224, "R5 control merge", got_data, 32'hAAAAA224);
        load(1, 32'h00000002, 32'h00000003);
        do_req(1'b0, 2'd2, '0);
        check(got_data == 32'h00000000, "R4 control fallback", got_data, 32'h0);
    endtask

    task automatic t_error_or;
        load(2, 32'h0F0F0001, 32'h00F00100);
        do_req(1'b0, 2'd1, '0);
        check(got_data == 32'h0FFF0101, "R7 error OR", got_data, 32'h0FFF0101);
    endtask

    task automatic t_write_dual;
        int d0;
        load(1, 32'h0, 32'h0);
        d0 = n_data;
        do_req(1'b1, 2'd2, 32'hDEADBEEF);
        check(!got_err, "R9 write ok", {31'b0, got_err}, 32'h0);
        check(regs[0][1] == 32'hDEADBEEF, "R9 dev0 written", regs[0][1], 32'hDEADBEEF);
        check(regs[1][1] == 32'hDEADBEEF, "R9 dev1 written", regs[1][1], 32'hDEADBEEF);
        check(log_dev[d0[3:0]] == 1'b0 && log_dev[4'(d0 + 1)] == 1'b1, "R9 write order",
              {30'b0, log_dev[d0[3:0]], log_dev[4'(d0 + 1)]}, 32'h1);
    endtask

    task automatic t_single;
        int d0;
        single_dev = 1'b1;
        load(0, 32'h00000135, 32'h00000246);
        d0 = n_data;
        do_req(1'b0, 2'd0, '0);
        check(got_data == 32'h00000135, "R8 single read raw", got_data, 32'h00000135);
        check((n_data - d0) == 1, "R8 one access", 32'(n_data - d0), 32'd1);
        load(2, 32'h0, 32'h0);
        do_req(1'b1, 2'd1, 32'h00000055);
        check(regs[0][2] == 32'h55 && regs[1][2] == 32'h0, "R8 single write",
              regs[1][2], 32'h0);
        single_dev = 1'b0;
    endtask

    task automatic t_bad;
        int d0, i0;
        d0 = n_data; i0 = n_idx;
        do_req(1'b0, 2'd3, '0);
        check(got_err, "R1 bad code error", {31'b0, got_err}, 32'h1);
        repeat (4) @(negedge clk);
        check(n_data == d0 && n_idx == i0, "R1 no traffic", 32'(n_data - d0), 32'h0);
    endtask

    task automatic t_busy;
        int d0, pulses;
        load(2, 32'h11110000, 32'h00002222);
        d0 = n_data;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_reg = 2'd1;
        @(negedge clk);
        check(busy, "R10 busy after accept", {31'b0, busy}, 32'h1);
        req_write = 1'b1; req_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin
                pulses++;
                got_data = rsp_rdata;
            end
            @(negedge clk);
        end
        check(pulses == 1, "R10 one response", 32'(pulses), 32'd1);
        check(got_data == 32'h11112222, "R10 first request served", got_data, 32'h11112222);
        check(regs[0][2] == 32'h11110000 && regs[1][2] == 32'h00002222,
              "R10 busy request ignored", regs[0][2], 32'h11110000);
        check((n_data - d0) == 2, "R10 no extra access", 32'(n_data - d0), 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status_merge();
        t_status_fallback();
        t_control_merge();
        t_error_or();
        t_write_dual();
        t_single();
        t_bad();
        t_busy();
        check(hold_viol == 0, "R11 stall hold", 32'(hold_viol), 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule